// File: doc/BRIEF.md
# Port Activity LED Stretcher

This block drives the activity indicator of one port of a two-port media converter. The indicator has three states: driven low, driven high and released. A higher level supplies a detected-speed code, a flag that is set while negotiation bursts arrive, and a flag that is set while a data packet is seen. From these the block works out whether the pad is enabled, and which level it drives. The data value is always 0, so the only visible states are "pulled low" and "released". When the port has no speed, the indicator tracks negotiation activity. When a speed is present, it tracks packets, and each packet is held long enough to be seen.

All timing comes from the 25 MHz reference clock through one free-running prescaler. The prescaler emits a tick every `PRESCALE_NORM` cycles, or every `PRESCALE_FAST` cycles when the fast-test input is set. A packet hold lasts until the second prescaler tick after the last packet cycle. With the default values this gives 1.35 to 2.7 ms of hold in normal operation and 164 to 328 µs in fast-test operation.

The controller has three named states. `ST_HIZ` means the pad is released. `ST_NEG` means negotiation is shown. `ST_PKT` means a packet hold is in progress. Its transitions are:

- `ST_HIZ`/`ST_NEG` → `ST_PKT` on a packet while a speed is present.
- `ST_HIZ` → `ST_NEG` on a burst while the speed is none.
- `ST_NEG` → `ST_HIZ` when the burst ends or a speed appears without a packet.
- `ST_PKT` → `ST_PKT` with the timer restarted on a further packet.
- `ST_PKT` → `ST_NEG` or `ST_HIZ` at once when the speed falls to none. The target is `ST_NEG` if a burst is active, otherwise `ST_HIZ`.
- `ST_PKT` → `ST_HIZ` when the hold timer expires.

Top module: `port_led_stretch`

## Requirements
- R1: A synchronous active-low reset releases the pad (`led_oe`=0) and clears the hold timer and prescaler.
- R2: With speed code 2'b00 (none), `led_oe` is 1 in the cycle after any cycle with `aneg_rx`=1, and 0 in the cycle after `aneg_rx` falls.
- R3: With a speed present (code 2'b01 = 10 Mb/s, 2'b10 = 100 Mb/s; 2'b11 is also treated as present), `aneg_rx` alone has no effect: the pad stays released.
- R4: With a speed present, `led_oe` is 1 in the cycle after any cycle with `pkt_seen`=1.
- R5: In normal mode, a single-cycle packet keeps `led_oe` at 1 for L cycles, where PRESCALE_NORM+2 ≤ L ≤ 2·PRESCALE_NORM+1.
- R6: With `fast_mode`=1 the same bound holds with PRESCALE_FAST in place of PRESCALE_NORM.
- R7: A packet during an active hold restarts it: after the last packet the hold again lasts within the R5 bound.
- R8: A change of speed code to none during a hold ends it in the next cycle. The pad is released unless `aneg_rx` is 1.
- R9: With speed none, `pkt_seen` has no effect: the pad stays released when `aneg_rx` is 0.
- R10: `led_dat` is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_code | input | 2 | Detected speed: 00 none, 01 10 Mb/s, 10 100 Mb/s |
| aneg_rx | input | 1 | Negotiation bursts being received |
| pkt_seen | input | 1 | Data packet being detected |
| fast_mode | input | 1 | Shortened test timescale |
| led_oe | output | 1 | Pad enable; 1 pulls the pad to `led_dat` |
| led_dat | output | 1 | Pad data value, always 0 |

## Verification
A single-cycle packet is swept across every phase of the prescaler period, in both normal and fast modes. Every measured hold length must lie inside the arithmetic window. This separates a correct two-tick hold from a one-tick or three-tick hold, and from a prescaler that ignores the mode.

Further patterns each isolate one input:

- Bursts under each speed code show whether negotiation is wrongly shown once a link exists.
- Packets without a speed show whether the speed gating has been lost.
- A second packet in mid-hold distinguishes a restart from a timer that keeps running.
- A speed drop in mid-hold shows whether the hold is abandoned at once.

// File: rtl/port_led_pkg.sv
package port_led_pkg;

    typedef enum logic [1:0] {
        ST_HIZ = 2'd0,
        ST_NEG = 2'd1,
        ST_PKT = 2'd2
    } led_state_t;

    localparam logic [1:0] SPD_NONE = 2'b00;

endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
    parameter int unsigned PRESCALE_NORM = 33750,
    parameter int unsigned PRESCALE_FAST = 4100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_mode,
    output logic tick
);
    localparam int unsigned MAXP = (PRESCALE_NORM > PRESCALE_FAST) ? PRESCALE_NORM : PRESCALE_FAST;
    localparam int unsigned CW   = $clog2(MAXP + 1);

    logic [CW-1:0] pcnt;
    logic [CW-1:0] limit_m1;

    always_comb begin
        limit_m1 = fast_mode ? CW'(PRESCALE_FAST - 1) : CW'(PRESCALE_NORM - 1);
        tick     = (pcnt >= limit_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/led_hold_timer.sv
module led_hold_timer #(
    parameter int unsigned HOLD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic expired
);
    localparam int unsigned TW = $clog2(HOLD_TICKS + 1);

    logic [TW-1:0] tcnt;

    assign expired = (tcnt == TW'(HOLD_TICKS));

    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= TW'(HOLD_TICKS);
        else if (start)
            tcnt <= '0;
        else if (tick && !expired)
            tcnt <= tcnt + 1'b1;
    end
endmodule

// File: rtl/port_led_stretch.sv
module port_led_stretch
    import port_led_pkg::*;
#(
    parameter int unsigned PRESCALE_NORM = 33750,
    parameter int unsigned PRESCALE_FAST = 4100,
    parameter int unsigned HOLD_TICKS    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_code,
    input  logic       aneg_rx,
    input  logic       pkt_seen,
    input  logic       fast_mode,
    output logic       led_oe,
    output logic       led_dat
);
    led_state_t state, state_nx;
    logic       tick;
    logic       expired;
    logic       has_speed;
    logic       pkt_hit;
    logic       neg_hit;

    assign has_speed = (speed_code != SPD_NONE);
    assign pkt_hit   = has_speed && pkt_seen;
    assign neg_hit   = !has_speed && aneg_rx;

    led_prescaler #(
        .PRESCALE_NORM(PRESCALE_NORM),
        .PRESCALE_FAST(PRESCALE_FAST)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_mode(fast_mode),
        .tick     (tick)
    );

    led_hold_timer #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pkt_hit),
        .tick   (tick),
        .expired(expired)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HIZ: begin
                if (pkt_hit)      state_nx = ST_PKT;
                else if (neg_hit) state_nx = ST_NEG;
            end
            ST_NEG: begin
                if (pkt_hit)       state_nx = ST_PKT;
                else if (!neg_hit) state_nx = ST_HIZ;
            end
            ST_PKT: begin
                if (!has_speed)   state_nx = aneg_rx ? ST_NEG : ST_HIZ;
                else if (pkt_hit) state_nx = ST_PKT;
                else if (expired) state_nx = ST_HIZ;
            end
            default: state_nx = ST_HIZ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_HIZ;
        else
            state <= state_nx;
    end

    always_comb begin
        led_oe  = (state != ST_HIZ);
        led_dat = 1'b0;
    end
endmodule

// File: rtl/port_led_stretch_chk.sv
module port_led_stretch_chk #(
    parameter int unsigned NORM = 33750,
    parameter int unsigned FAST = 4100
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] speed_code,
    input logic       aneg_rx,
    input logic       pkt_seen,
    input logic       led_oe,
    input logic       led_dat
);
    localparam int unsigned MAXP  = (NORM > FAST) ? NORM : FAST;
    localparam int unsigned BOUND = 2 * MAXP + 2;

    logic [31:0] since_pkt;

    always_ff @(posedge clk) begin
        if (!rst_n || speed_code == 2'b00 || pkt_seen)
            since_pkt <= '0;
        else if (led_oe && since_pkt != 32'hFFFF_FFFF)
            since_pkt <= since_pkt + 1;
    end

    // R1
    reset_release_chk: assert property (@(posedge clk) !rst_n |=> !led_oe);

    // R2
    neg_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_code == 2'b00 && aneg_rx) |=> led_oe);

    // R4
    pkt_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_code != 2'b00 && pkt_seen) |=> led_oe);

    // R9
    nolink_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_code == 2'b00 && !aneg_rx) |=> !led_oe);

    // R3
    link_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_oe && speed_code != 2'b00 && !pkt_seen) |=> !led_oe);

    // R5
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_oe |-> (since_pkt <= BOUND));

    // R10
    dat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_oe |-> !led_dat);
endmodule

bind port_led_stretch port_led_stretch_chk #(
    .NORM(PRESCALE_NORM),
    .FAST(PRESCALE_FAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_code(speed_code),
    .aneg_rx   (aneg_rx),
    .pkt_seen  (pkt_seen),
    .led_oe    (led_oe),
    .led_dat   (led_dat)
);

// File: tb/sim_port_led_stretch.sv
module sim_port_led_stretch;
    localparam int CLK_PERIOD = 40;
    localparam int TN = 40;
    localparam int TF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_code = 2'b00;
    logic       aneg_rx = 1'b0;
    logic       pkt_seen = 1'b0;
    logic       fast_mode = 1'b0;
    logic       led_oe;
    logic       led_dat;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    port_led_stretch #(
        .PRESCALE_NORM(TN),
        .PRESCALE_FAST(TF),
        .HOLD_TICKS   (2)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_code(speed_code),
        .aneg_rx   (aneg_rx),
        .pkt_seen  (pkt_seen),
        .fast_mode (fast_mode),
        .led_oe    (led_oe),
        .led_dat   (led_dat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulses one packet cycle, returns number of cycles led_oe stays 1.
    task automatic hold_len(output int len);
        len = 0;
        pkt_seen = 1'b1;
        @(negedge clk);
        pkt_seen = 1'b0;
        while (led_oe && len < 1000) begin
            len++;
            check(led_dat == 1'b0, "R10", led_dat, 0);
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int len;
        step(3);
        // R1: reset state
        check(led_oe == 1'b0, "R1", led_oe, 0);
        rst_n = 1'b1;
        step(2);
        check(led_oe == 1'b0, "R1", led_oe, 0);

        // R2: negotiation shown with no speed, released after
        aneg_rx = 1'b1;
        step(1);
        check(led_oe == 1'b1, "R2", led_oe, 1);
        check(led_dat == 1'b0, "R10", led_dat, 0);
        step(5);
        check(led_oe == 1'b1, "R2", led_oe, 1);
        aneg_rx = 1'b0;
        step(1);
        check(led_oe == 1'b0, "R2", led_oe, 0);

        // R3: burst ignored under every present speed code
        for (int s = 1; s < 4; s++) begin
            speed_code = 2'(s);
            aneg_rx = 1'b1;
            step(4);
            check(led_oe == 1'b0, "R3", led_oe, 0);
            aneg_rx = 1'b0;
            step(1);
        end

        // R9: packet ignored with no speed
        speed_code = 2'b00;
        pkt_seen = 1'b1;
        step(4);
        check(led_oe == 1'b0, "R9", led_oe, 0);
        pkt_seen = 1'b0;
        step(1);

        // R4: packet shown next cycle, for each speed code
        for (int s = 1; s < 4; s++) begin
            speed_code = 2'(s);
            pkt_seen = 1'b1;
            step(1);
            check(led_oe == 1'b1, "R4", led_oe, 1);
            pkt_seen = 1'b0;
            step(3 * TN);
        end

        // R5: sweep packet over every prescaler phase, normal mode
        speed_code = 2'b10;
        for (int ph = 0; ph < TN; ph++) begin
            step(ph + 1);
            hold_len(len);
            check(len >= TN + 2 && len <= 2 * TN + 1, "R5", len, TN + 2);
        end

        // R6: sweep in fast mode
        fast_mode = 1'b1;
        step(2 * TF);
        for (int ph = 0; ph < TF; ph++) begin
            step(ph + 1);
            hold_len(len);
            check(len >= TF + 2 && len <= 2 * TF + 1, "R6", len, TF + 2);
        end
        fast_mode = 1'b0;
        step(2 * TN);

        // R7: retrigger in mid-hold restarts the timer
        for (int k = 0; k < 4; k++) begin
            hold_len(len);
            step(0);
            pkt_seen = 1'b1;
            @(negedge clk);
            pkt_seen = 1'b0;
            step(TN - 1 + k * 7);
            check(led_oe == 1'b1, "R7", led_oe, 1);
            pkt_seen = 1'b1;
            @(negedge clk);
            pkt_seen = 1'b0;
            len = 0;
            while (led_oe && len < 1000) begin
                len++;
                @(negedge clk);
            end
            check(len >= TN + 2 && len <= 2 * TN + 1, "R7", len, TN + 2);
        end

        // R8: speed falls to none mid-hold
        pkt_seen = 1'b1;
        @(negedge clk);
        pkt_seen = 1'b0;
        step(3);
        speed_code = 2'b00;
        step(1);
        check(led_oe == 1'b0, "R8", led_oe, 0);
        speed_code = 2'b01;
        pkt_seen = 1'b1;
        @(negedge clk);
        pkt_seen = 1'b0;
        step(3);
        speed_code = 2'b00;
        aneg_rx = 1'b1;
        step(1);
        check(led_oe == 1'b1, "R8", led_oe, 1);
        aneg_rx = 1'b0;
        step(1);
        check(led_oe == 1'b0, "R8", led_oe, 0);

        // R1: reset in mid-hold releases pad
        speed_code = 2'b10;
        pkt_seen = 1'b1;
        @(negedge clk);
        pkt_seen = 1'b0;
        rst_n = 1'b0;
        step(1);
        check(led_oe == 1'b0, "R1", led_oe, 0);
        rst_n = 1'b1;
        step(2);
        check(led_oe == 1'b0, "R1", led_oe, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule